// File: doc/BRIEF.md
# Symbol-Level Tracking Meter for an Optical Receiver

This block estimates the received photocurrent level of one symbol value: either the optical "one" level or the optical "zero" level. It is not an average over both. It borrows the comparator of one receiver half, together with that comparator's capacitive offset DAC, and runs a slow successive-tracking loop. Each cycle the comparator says whether the input sits above or below the present DAC threshold. The 5-bit threshold code then moves one step toward the input.

The second receiver half keeps decoding data as usual. Its decided bit serves as a qualifier. A comparator sample counts only when the concurrent data bit equals the symbol level being measured. Because of this, a change in the mix of ones and zeros on the line does not look like a change in level.

The block is clocked by a slow clock, the data clock divided by 64. It publishes a registered reading with a one-cycle strobe after every 32 counted samples. Deasserting the enable returns the comparator to data reception and holds the code where it is.

Top module: `rx_level_meter`

## Requirements
- R1: While rst_n is low at a rising clock edge, the DAC code becomes 16 (mid-scale), the reading becomes 0, the strobe is low and the sample counter clears.
- R2: A counted sample (meter_en high, cond_bit equal to lvl_sel, lvl_sel unchanged) moves dac_code one step at that clock edge. The step is up by one when cmp_hi is 1 and down by one when cmp_hi is 0.
- R3: A sample whose cond_bit differs from lvl_sel does not move dac_code and does not advance the sample counter. lvl_sel = 1 selects the one level and lvl_sel = 0 selects the zero level.
- R4: The code saturates. An up step at 31 leaves 31, and a down step at 0 leaves 0.
- R5: On the edge of every 32nd counted sample since the last clear, meter_q takes the code produced by that sample. meter_vld is high for exactly the following cycle.
- R6: A clock edge at which lvl_sel differs from its value at the previous edge sets dac_code to 16, clears the sample counter, makes no step and raises no strobe.
- R7: While meter_en is low (and lvl_sel is unchanged), dac_code, the sample counter and meter_q hold their values, and meter_vld stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow meter clock (data clock divided by 64) |
| rst_n | input | 1 | Synchronous active-low reset |
| meter_en | input | 1 | 1: comparator used by the meter; 0: comparator returned to data, code frozen |
| lvl_sel | input | 1 | Symbol level to track: 1 = one level, 0 = zero level |
| cmp_hi | input | 1 | Comparator decision: 1 = input above the DAC threshold |
| cond_bit | input | 1 | Data bit decided by the other receiver half in the same cycle |
| dac_code | output | 5 | Threshold code to the capacitive offset DAC |
| meter_q | output | 5 | Registered level reading |
| meter_vld | output | 1 | One-cycle strobe marking a new reading |

## Verification
The loop is first driven with matched qualifier bits and a steady comparator decision. This separates a correct single step from a skipped or doubled step, and it carries the code into both saturation limits, where a wrap would show. Runs with the qualifier deliberately mismatched, interleaved with matched samples, show whether the gating blocks both the code and the sample count: the strobe must arrive after exactly 32 counted samples and not after 32 cycles. Switching the level select mid-run and dropping the enable for a stretch test the mid-scale restart and the frozen hold. A final mixed comparator pattern confirms the step direction follows each decision.

// File: rtl/lvl_pkg.sv
// Package: shared helpers for the symbol-level tracking meter.
// Assumes codes are unsigned and saturate at both ends of their range.
package lvl_pkg;

    // Saturating one-step move of an unsigned code of width w.
    function automatic logic [15:0] sat_step(input logic [15:0] code,
                                             input logic up,
                                             input int unsigned w);
        logic [15:0] top;
        top = (16'd1 << w) - 16'd1;
        if (up)
            sat_step = (code >= top) ? top : code + 16'd1;
        else
            sat_step = (code == 16'd0) ? 16'd0 : code - 16'd1;
    endfunction

endpackage

// File: rtl/lvl_gate.sv
// Module: lvl_gate
// Decides, per slow-clock cycle, whether the comparator sample counts
// toward the measurement, and detects a change of the tracked level.
// Assumes lvl_sel and cond_bit are already synchronous to clk.
module lvl_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic meter_en,
    input  logic lvl_sel,
    input  logic cond_bit,
    output logic sel_chg,
    output logic upd
);

    logic sel_prev;

    // Remember the level select of the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_prev <= lvl_sel;
        else        sel_prev <= lvl_sel;
    end

    // Qualify a sample: enabled, no level change, data bit matches level.
    always_comb begin
        sel_chg = (lvl_sel != sel_prev);
        upd     = meter_en && !sel_chg && (cond_bit == lvl_sel);
    end

    AST_SEL_BLOCKS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sel != sel_prev) |-> !upd); // R6

endmodule

// File: rtl/lvl_stepper.sv
// Module: lvl_stepper
// Holds the DAC threshold code and moves it one saturating step per
// qualified sample; a clear request restores mid-scale.
// Assumes clr and upd are never both acted on (clr wins).
module lvl_stepper
    import lvl_pkg::*;
#(
    parameter int unsigned CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic              up,
    output logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] code_nxt
);

    localparam logic [CODE_W-1:0] MID   = CODE_W'(1 << (CODE_W - 1));
    localparam logic [CODE_W-1:0] TOPC  = {CODE_W{1'b1}};

    logic [CODE_W-1:0] code_q;
    logic [15:0]       stepped;

    // Next code: clear to mid-scale, step, or hold.
    always_comb begin
        stepped = sat_step(16'(code_q), up, CODE_W);
        if (clr)      code_nxt = MID;
        else if (upd) code_nxt = stepped[CODE_W-1:0];
        else          code_nxt = code_q;
    end

    // Code register.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= MID;
        else        code_q <= code_nxt;
    end

    assign code = code_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (code_q == $past(code_q)) || (code_q == $past(code_q) + 1'b1)
                 || (code_q == $past(code_q) - 1'b1)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && upd && up && code_q == TOPC) |=> (code_q == TOPC)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && upd && !up && code_q == '0) |=> (code_q == '0)); // R4

endmodule

// File: rtl/lvl_report.sv
// Module: lvl_report
// Counts qualified samples and, on every UPD_PER_REPORT-th one, latches
// the freshly stepped code as the reading with a one-cycle strobe.
// Assumes code_nxt is the code the stepper will hold after this edge.
module lvl_report #(
    parameter int unsigned CODE_W         = 5,
    parameter int unsigned UPD_PER_REPORT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [CODE_W-1:0] code_nxt,
    output logic [CODE_W-1:0] meter_q,
    output logic              meter_vld
);

    localparam int unsigned CNT_W = (UPD_PER_REPORT > 2) ? $clog2(UPD_PER_REPORT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UPD_PER_REPORT - 1);

    logic [CNT_W-1:0] cnt;
    logic             last_upd;

    // The sample that completes a window.
    always_comb last_upd = upd && !clr && (cnt == LAST);

    // Sample counter: cleared on level change, wraps after a window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (last_upd)  cnt <= '0;
        else if (upd)       cnt <= cnt + 1'b1;
    end

    // Reading register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meter_q   <= '0;
            meter_vld <= 1'b0;
        end else begin
            meter_vld <= last_upd;
            if (last_upd) meter_q <= code_nxt;
        end
    end

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        meter_vld |=> !meter_vld); // R5
    AST_READING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !last_upd |=> $stable(meter_q)); // R7

endmodule

// File: rtl/rx_level_meter.sv
// Module: rx_level_meter (top)
// Data-conditioned tracking meter: steps a DAC code from comparator
// decisions on samples whose concurrent data bit equals the selected
// symbol level, and reports the code every UPD_PER_REPORT such samples.
// Assumes clk is the slow meter clock and all inputs are synchronous.
module rx_level_meter #(
    parameter int unsigned CODE_W         = 5,
    parameter int unsigned UPD_PER_REPORT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meter_en,
    input  logic              lvl_sel,
    input  logic              cmp_hi,
    input  logic              cond_bit,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] meter_q,
    output logic              meter_vld
);

    localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

    logic              sel_chg;
    logic              upd;
    logic [CODE_W-1:0] code_nxt;

    lvl_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .meter_en (meter_en),
        .lvl_sel  (lvl_sel),
        .cond_bit (cond_bit),
        .sel_chg  (sel_chg),
        .upd      (upd)
    );

    lvl_stepper #(.CODE_W(CODE_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sel_chg),
        .upd      (upd),
        .up       (cmp_hi),
        .code     (dac_code),
        .code_nxt (code_nxt)
    );

    lvl_report #(.CODE_W(CODE_W), .UPD_PER_REPORT(UPD_PER_REPORT)) u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sel_chg),
        .upd       (upd),
        .code_nxt  (code_nxt),
        .meter_q   (meter_q),
        .meter_vld (meter_vld)
    );

    AST_MISMATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (meter_en && !sel_chg && cond_bit != lvl_sel) |=> $stable(dac_code)); // R3
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!meter_en && !sel_chg) |=> ($stable(dac_code) && !meter_vld)); // R7
    AST_MID_ON_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (dac_code == MID && !meter_vld)); // R6

endmodule

// File: tb/sim_rx_level_meter.sv
// Scoreboard bench: the driver task applies one cycle of stimulus and
// pushes the expected outputs; the monitor pops and compares after the edge.
module sim_rx_level_meter;

    typedef struct {
        logic [4:0] code;
        logic [4:0] meter;
        logic       vld;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       meter_en = 1'b0;
    logic       lvl_sel = 1'b1;
    logic       cmp_hi = 1'b0;
    logic       cond_bit = 1'b0;
    logic [4:0] dac_code;
    logic [4:0] meter_q;
    logic       meter_vld;

    int n_cmp = 0;
    int n_bad = 0;
    exp_t q[$];

    // Bench reference state, built from the requirements.
    int m_code = 16, m_cnt = 0, m_meter = 0;
    logic m_sel = 1'b1;

    always #4 clk = ~clk; // 125 MHz

    rx_level_meter u0 (
        .clk(clk), .rst_n(rst_n), .meter_en(meter_en), .lvl_sel(lvl_sel),
        .cmp_hi(cmp_hi), .cond_bit(cond_bit), .dac_code(dac_code),
        .meter_q(meter_q), .meter_vld(meter_vld)
    );

    task automatic drive(input logic rst, input logic en, input logic sel,
                         input logic cmp, input logic cond, input string req);
        exp_t e;
        logic vld;
        @(negedge clk);
        rst_n = rst; meter_en = en; lvl_sel = sel; cmp_hi = cmp; cond_bit = cond;
        vld = 1'b0;
        if (!rst) begin
            m_code = 16; m_cnt = 0; m_meter = 0; m_sel = sel;
        end else if (sel != m_sel) begin
            m_code = 16; m_cnt = 0; m_sel = sel;
        end else if (en && cond == sel) begin
            if (cmp) m_code = (m_code == 31) ? 31 : m_code + 1;
            else     m_code = (m_code == 0) ? 0 : m_code - 1;
            if (m_cnt == 31) begin
                m_meter = m_code; vld = 1'b1; m_cnt = 0;
            end else m_cnt = m_cnt + 1;
        end
        e.code = 5'(m_code); e.meter = 5'(m_meter); e.vld = vld; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compare after each rising edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp += 3;
            if (dac_code !== e.code) begin
                n_bad++;
                $display("FAIL %s dac_code actual=%0d expected=%0d", e.req, dac_code, e.code);
            end
            if (meter_vld !== e.vld) begin
                n_bad++;
                $display("FAIL %s meter_vld actual=%0b expected=%0b", e.req, meter_vld, e.vld);
            end
            if (meter_q !== e.meter) begin
                n_bad++;
                $display("FAIL %s meter_q actual=%0d expected=%0d", e.req, meter_q, e.meter);
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        repeat (5) drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R2");
        repeat (6) drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R2");
            drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
        end
        repeat (20) drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4");
        repeat (10) drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
        repeat (3) drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 40; i++) begin
            drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
            if (i % 3 == 0) drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
        end
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
        for (int i = 0; i < 80; i++)
            drive(1'b1, 1'b1, 1'b1, ((i * 7) % 3) != 0, (i % 5) != 1, "R5");
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R1");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R2");
        @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule